// File: doc/BRIEF.md
# Serial Port Register and Interrupt Frontend

This block is the software-visible face of a byte-oriented serial port. It sits on a simple 32-bit word bus with a combinational read path and exposes a small set of word registers. Three of them are plain control words: transmit control, transmit DMA enable and receive control. There is also an interrupt mask, a one-shot interrupt acknowledge, and a combined status/data word. That word carries the last received byte, a data-available flag and two transmitter flags. It has two read addresses: one clears data-available as a side effect, the other only looks. The block keeps a raw interrupt vector and its masked view, and it drives one level interrupt line.

Bytes written to the transmit data register leave on a valid/ready byte stream. The byte is held with `tx_valid` high and `tx_data` stable until the sink raises `tx_ready`. While a byte is held, further writes to the data register are dropped. Received bytes arrive on a second valid/ready stream. A byte is taken on any edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low only when the receive enable bit is clear and a previous receive interrupt is still unacknowledged. No byte is buffered beyond the status word.

A bus access happens on a clock edge with `bus_sel` high. `bus_word` marks a full-word access. Read data is valid in the same cycle, and side effects take place at the edge.

Top module: `serport_regs`

## Requirements
- R1: After reset the status word reads 0x0140_0000, with transmitter-ready in bit 24 and transmitter-idle in bit 22 set and data-available (bit 16) clear. The raw interrupt vector reads 0, `irq` is low and `tx_valid` is low.
- R2: The word registers at offsets 0x00 (transmit control), 0x04 (DMA enable), 0x08 (receive control) and 0x2C (interrupt mask) store a full written word and read it back. Writes to 0x20, 0x24, 0x34 and 0x38 change nothing. Reads of 0x1C, 0x30 and of every unlisted offset return 0.
- R3: An access with `bus_word` low reads 0 and has no effect on any register, including the clear-on-read flag.
- R4: A word write to 0x1C while no byte is held places bits 7:0 of the written value on `tx_data`, with `tx_valid` high. The byte stays there unchanged until the edge where `tx_ready` is high. The write sets raw interrupt bit 0. Status bits 22 and 24 read 0 while the byte is held.
- R5: A write to 0x1C while a byte is still held is dropped: `tx_data` keeps the held byte.
- R6: An accepted receive byte replaces status bits 7:0, sets data-available (bit 16) and sets raw interrupt bit 3.
- R7: A read of 0x20 returns the status word and then clears bit 16. A read of 0x24 returns the same word and leaves it unchanged.
- R8: `rx_ready` is high when receive control bit 0 is set or raw interrupt bit 3 is clear. A byte offered while `rx_ready` is low is not taken.
- R9: A word write to 0x30 clears every raw interrupt bit that is set in the written value. The acknowledge register always reads 0.
- R10: A transmit write marks a transmit as pending. The first acknowledge with bit 0 set after it leaves raw bit 0 set and drops the pending mark. A later acknowledge with bit 0 set clears raw bit 0.
- R11: Offset 0x38 reads the raw vector ANDed with the mask register, and `irq` is high exactly when that value is non-zero.
- R12: A byte accepted in the same cycle as an acknowledge of bit 3 leaves raw bit 3 set. A byte accepted in the same cycle as a read of 0x20 leaves data-available set; that read returns the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | Full-word access; low marks a narrow access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address and state |
| tx_valid | output | 1 | Transmit byte held |
| tx_ready | input | 1 | Transmit sink takes the byte |
| tx_data | output | BYTE_W | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Block can take a receive byte |
| rx_data | input | BYTE_W | Receive byte |
| irq | output | 1 | Level interrupt, any masked bit set |

## Verification
Two functions can meet in one edge: an incoming receive byte and a bus access that removes receive state. The access is either an acknowledge of raw bit 3 or a clear-on-read of the status word. The bench drives `rx_valid` and the bus access at the same falling edge, so both land on the same rising edge. It then reads the raw vector and the non-destructive status alias. The arriving byte must win in both cases: bit 3 and data-available stay set, and the read made in that cycle returns the previous byte.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int N_REG = 10;

  // Register indices into the decode vector
  localparam int IX_TXCTL  = 0;
  localparam int IX_DMAEN  = 1;
  localparam int IX_RXCTL  = 2;
  localparam int IX_TXDATA = 3;
  localparam int IX_STCLR  = 4;
  localparam int IX_STPEEK = 5;
  localparam int IX_MASK   = 6;
  localparam int IX_ACK    = 7;
  localparam int IX_RAW    = 8;
  localparam int IX_MASKED = 9;

  // Status word bit positions
  localparam int B_DAV   = 16;
  localparam int B_TIDLE = 22;
  localparam int B_TRDY  = 24;

  // Interrupt source bits
  localparam int I_TX = 0;
  localparam int I_RX = 3;

  function automatic logic [7:0] reg_ofs(input int idx);
    case (idx)
      IX_TXCTL:  reg_ofs = 8'h00;
      IX_DMAEN:  reg_ofs = 8'h04;
      IX_RXCTL:  reg_ofs = 8'h08;
      IX_TXDATA: reg_ofs = 8'h1C;
      IX_STCLR:  reg_ofs = 8'h20;
      IX_STPEEK: reg_ofs = 8'h24;
      IX_MASK:   reg_ofs = 8'h2C;
      IX_ACK:    reg_ofs = 8'h30;
      IX_RAW:    reg_ofs = 8'h34;
      default:   reg_ofs = 8'h38;
    endcase
  endfunction
endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_word,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [N_REG-1:0]    rd_stb,
  output logic [N_REG-1:0]    wr_stb
);
  logic [N_REG-1:0] match;
  logic             acc_ok;

  assign acc_ok = bus_sel & bus_word;

  for (genvar g = 0; g < N_REG; g++) begin : g_match
    assign match[g] = (bus_addr == ADDR_W'(reg_ofs(g)));
  end

  assign rd_stb = match & {N_REG{acc_ok & ~bus_wr}};
  assign wr_stb = match & {N_REG{acc_ok &  bus_wr}};
endmodule

// File: rtl/serport_txhold.sv
module serport_txhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              taken,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data
);
  assign taken = load & ~tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (taken) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R4: a held byte stays put until the sink takes it
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R5: a load while held does not replace the byte
  assert_drop_when_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && load) |=> $stable(tx_data));
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_set,
  input  logic              rx_set,
  input  logic              ack_wr,
  input  logic [DATA_W-1:0] ack_val,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_val,
  output logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] masked,
  output logic              irq
);
  logic              pend;
  logic              rearm;
  logic [DATA_W-1:0] ack_eff;
  logic [DATA_W-1:0] tx_bits;
  logic [DATA_W-1:0] rx_bits;
  logic [DATA_W-1:0] raw_n;

  always_comb begin
    ack_eff = ack_wr ? ack_val : '0;
    rearm   = pend & ack_eff[I_TX];
    if (rearm) ack_eff[I_TX] = 1'b0;
    tx_bits = '0;
    tx_bits[I_TX] = tx_set | rearm;
    rx_bits = '0;
    rx_bits[I_RX] = rx_set;
    // A new receive event is never cancelled by an acknowledge in its own cycle
    raw_n = ((raw | tx_bits) & ~ack_eff) | rx_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
      pend <= 1'b0;
    end else begin
      raw <= raw_n;
      if (mask_wr) mask <= mask_val;
      if (tx_set)     pend <= 1'b1;
      else if (rearm) pend <= 1'b0;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  // R9: an acknowledged receive bit is gone unless a new byte arrived
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_val[I_RX] && !rx_set) |=> !raw[I_RX]);

  // R10: first acknowledge of a pending transmit re-arms bit 0
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_val[I_TX] && pend) |=> (raw[I_TX] && !pend));

  // R12: a received byte always leaves raw bit 3 set
  assert_rx_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> raw[I_RX]);
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  logic [N_REG-1:0]  rd_stb;
  logic [N_REG-1:0]  wr_stb;
  logic [DATA_W-1:0] ctl_tx, ctl_dma, ctl_rx;
  logic [BYTE_W-1:0] rx_byte;
  logic              dav;
  logic              rx_acc;
  logic              tx_taken;
  logic [DATA_W-1:0] raw, mask, masked;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] view [N_REG];

  serport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_word(bus_word),
    .bus_addr(bus_addr),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb)
  );

  serport_txhold #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_stb[IX_TXDATA]),
    .load_byte(bus_wdata[BYTE_W-1:0]),
    .taken    (tx_taken),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );

  assign rx_ready = ctl_rx[0] | ~raw[I_RX];
  assign rx_acc   = rx_valid & rx_ready;

  serport_irq #(.DATA_W(DATA_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_set  (tx_taken),
    .rx_set  (rx_acc),
    .ack_wr  (wr_stb[IX_ACK]),
    .ack_val (bus_wdata),
    .mask_wr (wr_stb[IX_MASK]),
    .mask_val(bus_wdata),
    .raw     (raw),
    .mask    (mask),
    .masked  (masked),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_tx  <= '0;
      ctl_dma <= '0;
      ctl_rx  <= '0;
      rx_byte <= '0;
      dav     <= 1'b0;
    end else begin
      if (wr_stb[IX_TXCTL]) ctl_tx  <= bus_wdata;
      if (wr_stb[IX_DMAEN]) ctl_dma <= bus_wdata;
      if (wr_stb[IX_RXCTL]) ctl_rx  <= bus_wdata;
      if (rx_acc) begin
        rx_byte <= rx_data;
        dav     <= 1'b1;
      end else if (rd_stb[IX_STCLR]) begin
        dav <= 1'b0;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[BYTE_W-1:0] = rx_byte;
    stat_word[B_DAV]      = dav;
    stat_word[B_TIDLE]    = ~tx_valid;
    stat_word[B_TRDY]     = ~tx_valid;
  end

  always_comb begin
    view[IX_TXCTL]  = ctl_tx;
    view[IX_DMAEN]  = ctl_dma;
    view[IX_RXCTL]  = ctl_rx;
    view[IX_TXDATA] = '0;
    view[IX_STCLR]  = stat_word;
    view[IX_STPEEK] = stat_word;
    view[IX_MASK]   = mask;
    view[IX_ACK]    = '0;
    view[IX_RAW]    = raw;
    view[IX_MASKED] = masked;
    bus_rdata = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (rd_stb[i]) bus_rdata = bus_rdata | view[i];
    end
  end

  // R6: an accepted byte is captured with data-available set
  assert_rx_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc |=> (dav && rx_byte == $past(rx_data)));

  // R7: clear-on-read drops data-available when no byte arrives
  assert_dav_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb[IX_STCLR] && !rx_acc) |=> !dav);

  // R7: the alias read leaves data-available alone
  assert_peek_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb[IX_STPEEK] && !rx_acc) |=> $stable(dav));

  // R3: narrow accesses leave the control words untouched
  assert_narrow_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_word) |=> ($stable(ctl_tx) && $stable(ctl_rx) && $stable(ctl_dma)));
endmodule

// File: tb/serport_regs_test.sv
module serport_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] q;

  serport_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic [7:0] b, input logic d, input logic held);
    return {7'd0, ~held, 1'b0, ~held, 5'd0, d, 8'd0, b};
  endfunction

  // One bus access, optionally with a receive byte offered in the same cycle
  task automatic acc(input logic wr, input logic word, input logic [5:0] a,
                     input logic [31:0] d, input logic rxv, input logic [7:0] rxb,
                     output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_word = word; bus_addr = a; bus_wdata = d;
    rx_valid = rxv; rx_data = rxb;
    #2 r = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, 1'b1, a, d, 1'b0, 8'h00, r);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] r);
    acc(1'b0, 1'b1, a, 32'h0, 1'b0, 8'h00, r);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(6'h24, q); chk("R1 status", q, 32'h0140_0000);
    rd(6'h34, q); chk("R1 raw", q, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

    // R2 sweep over every word offset (transmit data excluded from writes)
    for (int i = 0; i < 16; i++) begin
      if (i != 7) wr(6'(i * 4), 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)));
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      logic [31:0] p;
      p = 32'hA500_0000 ^ (32'h0101_0101 * (i + 1));
      case (i)
        0, 1, 2, 11: e = p;
        8, 9:        e = stat(8'h00, 1'b0, 1'b0);
        default:     e = 32'h0;
      endcase
      rd(6'(i * 4), q); chk($sformatf("R2 offset %0h", i * 4), q, e);
    end
    wr(6'h2C, 32'h0); wr(6'h08, 32'h0);

    // R3 narrow accesses
    wr(6'h00, 32'h1111_2222);
    acc(1'b1, 1'b0, 6'h00, 32'hFFFF_FFFF, 1'b0, 8'h00, q);
    acc(1'b0, 1'b0, 6'h00, 32'h0, 1'b0, 8'h00, q);
    chk("R3 narrow read", q, 32'h0);
    rd(6'h00, q); chk("R3 narrow write", q, 32'h1111_2222);

    // R6 / R7 sweep over all byte values, receive enabled
    wr(6'h08, 32'h1);
    for (int b = 0; b < 256; b++) begin
      send(8'(b));
      rd(6'h24, q); chk("R6 capture", q, stat(8'(b), 1'b1, 1'b0));
      rd(6'h24, q); chk("R7 peek keeps", q, stat(8'(b), 1'b1, 1'b0));
      rd(6'h20, q); chk("R7 clr returns", q, stat(8'(b), 1'b1, 1'b0));
      rd(6'h24, q); chk("R7 clr clears", q, stat(8'(b), 1'b0, 1'b0));
    end
    rd(6'h34, q); chk("R6 raw bit3", q, 32'h8);
    acc(1'b0, 1'b0, 6'h20, 32'h0, 1'b0, 8'h00, q);
    send(8'h3C); acc(1'b0, 1'b0, 6'h20, 32'h0, 1'b0, 8'h00, q);
    rd(6'h24, q); chk("R3 narrow keeps dav", q, stat(8'h3C, 1'b1, 1'b0));
    rd(6'h20, q);

    // R8 receive back-pressure
    #2 chk("R8 ready enabled", {31'd0, rx_ready}, 32'd1);
    wr(6'h08, 32'h0);
    #2 chk("R8 ready blocked", {31'd0, rx_ready}, 32'd0);
    send(8'h77);
    rd(6'h24, q); chk("R8 byte not taken", q, stat(8'h3C, 1'b0, 1'b0));

    // R9 acknowledge
    wr(6'h30, 32'h1);
    rd(6'h34, q); chk("R9 other bit kept", q, 32'h8);
    wr(6'h30, 32'h8);
    rd(6'h34, q); chk("R9 cleared", q, 32'h0);
    rd(6'h30, q); chk("R9 ack reads zero", q, 32'h0);
    #2 chk("R8 ready after ack", {31'd0, rx_ready}, 32'd1);

    // R4 / R5 transmit hold and drop
    wr(6'h1C, 32'h1234_56C3);
    chk("R4 valid", {31'd0, tx_valid}, 32'd1);
    chk("R4 data", {24'd0, tx_data}, 32'hC3);
    rd(6'h24, q); chk("R4 status busy", q, stat(8'h3C, 1'b0, 1'b1));
    rd(6'h34, q); chk("R4 raw bit0", q, 32'h1);
    wr(6'h1C, 32'h99);
    chk("R5 dropped", {24'd0, tx_data}, 32'hC3);
    repeat (3) @(negedge clk);
    chk("R4 still held", {23'd0, tx_valid, tx_data}, 32'h1C3);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R4 released", {31'd0, tx_valid}, 32'd0);
    rd(6'h24, q); chk("R4 status idle", q, stat(8'h3C, 1'b0, 1'b0));

    // R10 pending transmit re-arm
    wr(6'h30, 32'h1);
    rd(6'h34, q); chk("R10 rearmed", q, 32'h1);
    wr(6'h30, 32'h1);
    rd(6'h34, q); chk("R10 cleared", q, 32'h0);

    // R4 sweep of transmit bytes with the sink always ready
    for (int b = 0; b < 256; b++) begin
      wr(6'h1C, 32'hABCD_0000 | 32'(b));
      chk("R4 sweep", {23'd0, tx_valid, tx_data}, 32'h100 | 32'(b));
    end
    wr(6'h30, 32'h1); wr(6'h30, 32'h1);
    rd(6'h34, q); chk("R10 after sweep", q, 32'h0);

    // R11 mask sweep with raw = 0x9
    wr(6'h1C, 32'h55);
    send(8'h5A);
    for (int m = 0; m < 16; m++) begin
      wr(6'h2C, 32'(m) | 32'hF000_0000);
      rd(6'h38, q); chk("R11 masked", q, 32'(m) & 32'h9);
      chk("R11 irq", {31'd0, irq}, {31'd0, |(4'(m) & 4'h9)});
    end
    wr(6'h2C, 32'h0);
    chk("R11 irq off", {31'd0, irq}, 32'd0);

    // R12 same-cycle receive against acknowledge and clear-on-read
    wr(6'h08, 32'h1);
    acc(1'b1, 1'b1, 6'h30, 32'h8, 1'b1, 8'hE1, q);
    rd(6'h34, q); chk("R12 ack vs rx raw", q & 32'h8, 32'h8);
    rd(6'h20, q); chk("R12 ack vs rx byte", q, stat(8'hE1, 1'b1, 1'b0));
    acc(1'b0, 1'b1, 6'h20, 32'h0, 1'b1, 8'h2B, q);
    chk("R12 clr returns old", q, stat(8'hE1, 1'b0, 1'b0));
    rd(6'h24, q); chk("R12 clr vs rx", q, stat(8'h2B, 1'b1, 1'b0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule